// File: doc/BRIEF.md
# Banked Host Register Window with Packet Buffer Pointer

This block gives a host a 16-byte register window on a synchronous 32-bit bus. The host addresses one of four 32-bit words and chooses byte lanes with byte enables. The register that appears at most byte offsets depends on a bank number. The host sets that number through a bank selector, which is visible in every bank. The selector also returns a fixed signature byte, so software can confirm that the window is present before it uses it.

Bank 2 holds the two registers that reach the packet buffer. The first is a 16-bit pointer with three flag bits:

- an area bit that selects the receive or transmit region;
- an auto-advance bit;
- a direction bit.

The second is a data port. The host reads and writes packet bytes through it one, two or four bytes at a time, starting at the pointer's byte offset. When auto-advance is on, the pointer moves past the bytes just transferred, so a host can stream a whole packet through one address. The packet buffer is an internal byte RAM with one region per area.

Top module: `regwin_top`

## Requirements
- R1: After reset the bank number is 0, the pointer is 0x0000 and host_rvalid is low.
- R2: A write with lane 2 enabled to word 3 (byte 0xE) loads the bank number from host_wdata[16 +: BANK_W]. This works whatever bank is selected. No other access changes the bank number.
- R3: A read of word 3 returns 0x33 on lane 3 (byte 0xF) and the bank number on lane 2, with the bits above it zero. Lanes 0 and 1 of word 3 read zero.
- R4: host_rvalid is high exactly in the cycle after a read request, and host_rdata is valid in that cycle. Lanes whose byte enable was clear read as zero.
- R5: In bank 2, word 1 lanes 2 and 3 (bytes 0x6 and 0x7) hold the pointer and can be written one byte at a time. Pointer bits 12 and 11 always read zero, and lanes 0 and 1 of word 1 read zero.
- R6: In bank 2, word 2 (byte 0x8) is the data port. Enabled lanes, taken from the lowest enabled lane upward, map to consecutive byte offsets starting at pointer bits 10:0. Each offset is taken modulo the region size of 2^BUF_AW bytes. Pointer bit 15 selects the receive region (1) or the transmit region (0), and the two regions are independent.
- R7: When pointer bit 14 is 1, each data port access that is carried out advances pointer bits 10:0 by the number of enabled lanes (1, 2 or 4), wrapping modulo 2048. Bits 15:13 do not change. When bit 14 is 0, the pointer does not move.
- R8: Pointer bit 13 set to 1 marks reads. In that state a data port write is ignored and the pointer does not move. With bit 13 at 0, a data port read returns zero and the pointer does not move.
- R9: Outside bank 2, words 0 to 2 are unimplemented. So are word 0 in bank 2 and word 3 lanes 0 and 1 in every bank. Writes to them change nothing and reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request this cycle |
| host_we | input | 1 | 1 for write, 0 for read |
| host_word | input | 2 | Word index inside the 16-byte window |
| host_be | input | 4 | Byte-lane enables |
| host_wdata | input | 32 | Write data, lane k on bits 8k+7:8k |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | High the cycle after a read request |

## Verification
The hardest state to reach is a multi-byte data access that starts just below the 2048-byte pointer wrap. The pointer offset then wraps while the buffer index also aliases at the region boundary. Directed steps preload the pointer to 0x7FE and issue four-byte writes and reads to reach it. Direction mismatches and accesses from a wrong bank are also directed, and the pointer is read back afterwards to show it did not move. A seeded random phase then mixes bank switches, pointer loads with random flags and data port traffic of all legal widths over a buffer whose contents the bench has filled.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int LANES       = 4;
  localparam int LANE_W      = 2;
  localparam int DATA_W      = LANES * 8;
  localparam int OFS_W       = 11;
  localparam int PTR_W       = 16;
  localparam int PTR_AREA_B  = 15;
  localparam int PTR_INC_B   = 14;
  localparam int PTR_RD_B    = 13;
  localparam int DATA_BANK   = 2;
  localparam logic [7:0] SIGNATURE = 8'h33;
  localparam logic [1:0] W_PTR  = 2'd1;
  localparam logic [1:0] W_DATA = 2'd2;
  localparam logic [1:0] W_BSEL = 2'd3;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_BSEL = 2'd1,
    TGT_PTR  = 2'd2,
    TGT_DATA = 2'd3
  } tgt_t;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic [1:0]        word,
  input  logic [BANK_W-1:0] bank,
  output tgt_t              tgt
);
  logic in_data_bank;

  always_comb begin
    in_data_bank = (bank == BANK_W'(DATA_BANK));
    tgt = TGT_NONE;
    if (word == W_BSEL) begin
      tgt = TGT_BSEL;
    end else if (in_data_bank && word == W_PTR) begin
      tgt = TGT_PTR;
    end else if (in_data_bank && word == W_DATA) begin
      tgt = TGT_DATA;
    end
  end
endmodule

// File: rtl/regwin_ptr.sv
module regwin_ptr
  import regwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_be,
  input  logic [PTR_W-1:0] wr_val,
  input  logic             step_en,
  input  logic [2:0]       step,
  output logic [PTR_W-1:0] ptr_q
);
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_ld;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_ld = wr_en | step_en;
    if (wr_en) begin
      if (wr_be[0]) ptr_d[7:0]  = wr_val[7:0];
      if (wr_be[1]) ptr_d[15:8] = wr_val[15:8];
      ptr_d[PTR_RD_B-1:OFS_W] = '0;
    end else if (step_en) begin
      ptr_d[OFS_W-1:0] = ptr_q[OFS_W-1:0] + OFS_W'(step);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_ld) begin
      ptr_q <= ptr_d;
    end
  end

  a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !wr_en) |=>
      (ptr_q[OFS_W-1:0] == $past(ptr_q[OFS_W-1:0]) + OFS_W'($past(step)))
      && (ptr_q[PTR_W-1:PTR_RD_B] == $past(ptr_q[PTR_W-1:PTR_RD_B])));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !wr_en) |=> $stable(ptr_q));
endmodule

// File: rtl/regwin_pktbuf.sv
module regwin_pktbuf
  import regwin_pkg::*;
#(
  parameter int BUF_AW = 7
) (
  input  logic              clk,
  input  logic              wr_go,
  input  logic              area,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_bytes,
  output logic [2:0]        width
);
  localparam int DEPTH = 2 ** (BUF_AW + 1);

  logic [7:0]        mem [DEPTH];
  logic [LANE_W-1:0] first;
  logic [BUF_AW:0]   idx [LANES];

  always_comb begin
    first = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (be[k]) first = LANE_W'(k);
    end
    width = 3'($countones(be));
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      idx[k] = {area, BUF_AW'(ofs + OFS_W'(k) - OFS_W'(first))};
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      rd_bytes[8*k +: 8] = be[k] ? mem[idx[k]] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (wr_go && be[k]) mem[idx[k]] <= wdata[8*k +: 8];
    end
  end
endmodule

// File: rtl/regwin_top.sv
module regwin_top
  import regwin_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int BUF_AW = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_we,
  input  logic [1:0]  host_word,
  input  logic [3:0]  host_be,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_rvalid
);
  localparam int PAD_W = 8 - BANK_W;

  tgt_t              tgt;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic              bsel_wr;
  logic              ptr_wr;
  logic [PTR_W-1:0]  ptr_q;
  logic              data_wr_go, data_rd_go, step_en;
  logic [DATA_W-1:0] buf_rd;
  logic [2:0]        acc_width;
  logic [DATA_W-1:0] rd_word, rd_masked;
  logic [DATA_W-1:0] rdata_d;
  logic              rvalid_d, rdata_ld;

  regwin_decode #(.BANK_W(BANK_W)) u_decode (
    .word (host_word),
    .bank (bank_q),
    .tgt  (tgt)
  );

  regwin_ptr u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ptr_wr),
    .wr_be   (host_be[3:2]),
    .wr_val  (host_wdata[31:16]),
    .step_en (step_en),
    .step    (acc_width),
    .ptr_q   (ptr_q)
  );

  regwin_pktbuf #(.BUF_AW(BUF_AW)) u_buf (
    .clk      (clk),
    .wr_go    (data_wr_go),
    .area     (ptr_q[PTR_AREA_B]),
    .ofs      (ptr_q[OFS_W-1:0]),
    .be       (host_be),
    .wdata    (host_wdata),
    .rd_bytes (buf_rd),
    .width    (acc_width)
  );

  // access qualification
  always_comb begin
    bsel_wr    = host_req && host_we && (tgt == TGT_BSEL) && host_be[2];
    bank_d     = host_wdata[16 +: BANK_W];
    ptr_wr     = host_req && host_we && (tgt == TGT_PTR) && (|host_be[3:2]);
    data_wr_go = host_req && host_we && (tgt == TGT_DATA) && !ptr_q[PTR_RD_B];
    data_rd_go = host_req && !host_we && (tgt == TGT_DATA) && ptr_q[PTR_RD_B];
    step_en    = (data_wr_go || data_rd_go) && ptr_q[PTR_INC_B] && (|host_be);
  end

  // read path
  always_comb begin
    case (tgt)
      TGT_BSEL: rd_word = {SIGNATURE, {PAD_W{1'b0}}, bank_q, 16'h0000};
      TGT_PTR:  rd_word = {ptr_q, 16'h0000};
      TGT_DATA: rd_word = ptr_q[PTR_RD_B] ? buf_rd : '0;
      default:  rd_word = '0;
    endcase
    for (int k = 0; k < LANES; k++) begin
      rd_masked[8*k +: 8] = host_be[k] ? rd_word[8*k +: 8] : 8'h00;
    end
    rvalid_d = host_req && !host_we;
    rdata_ld = rvalid_d;
    rdata_d  = rd_masked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (bsel_wr) begin
      bank_q <= bank_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= rvalid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (rdata_ld) begin
      host_rdata <= rdata_d;
    end
  end

  a_r2_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bsel_wr |=> $stable(bank_q));

  a_r4_rvalid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we) |=> host_rvalid);

  a_r4_rvalid_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && !host_we) |=> !host_rvalid);

  a_r3_signature: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we && host_word == W_BSEL && host_be[3])
      |=> (host_rdata[31:24] == SIGNATURE));

  a_r8_wr_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && tgt == TGT_DATA && ptr_q[PTR_RD_B]) |=> $stable(ptr_q));

  a_r9_no_target: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && tgt == TGT_NONE) |=> ($stable(ptr_q) && $stable(bank_q)));
endmodule

// File: tb/regwin_top_bench.sv
module regwin_top_bench;
  logic        clk;
  logic        rst_n;
  logic        host_req;
  logic        host_we;
  logic [1:0]  host_word;
  logic [3:0]  host_be;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        host_rvalid;

  regwin_top u_regwin_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .host_we     (host_we),
    .host_word   (host_word),
    .host_be     (host_be),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int          n_chk;
  int          n_err;
  logic [2:0]  m_bank;
  logic [15:0] m_ptr;
  logic [7:0]  m_mem [256];
  logic [3:0]  be_set [7];
  logic [31:0] rd;

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic int m_tgt(input logic [1:0] w);
    if (w == 2'd3) return 1;
    if (m_bank == 3'd2 && w == 2'd1) return 2;
    if (m_bank == 3'd2 && w == 2'd2) return 3;
    return 0;
  endfunction

  // reference model: returns expected read data and applies the side effects
  task automatic m_apply(input logic we, input logic [1:0] w, input logic [3:0] be,
                         input logic [31:0] wd, output logic [31:0] exp);
    logic [31:0] word_v;
    int n;
    int ix;
    word_v = 32'h0;
    case (m_tgt(w))
      1: begin
        word_v = {8'h33, 5'b0, m_bank, 16'h0};
        if (we && be[2]) m_bank = wd[18:16];
      end
      2: begin
        word_v = {m_ptr, 16'h0};
        if (we && (be[2] || be[3])) begin
          if (be[2]) m_ptr[7:0]  = wd[23:16];
          if (be[3]) m_ptr[15:8] = wd[31:24];
          m_ptr[12:11] = 2'b00;
        end
      end
      3: begin
        if (we != m_ptr[13]) begin
          n = 0;
          for (int k = 0; k < 4; k++) begin
            if (be[k]) begin
              ix = (m_ptr[15] ? 128 : 0) + ((int'(m_ptr[10:0]) + n) % 128);
              if (we) m_mem[ix] = wd[8*k +: 8];
              else word_v[8*k +: 8] = m_mem[ix];
              n++;
            end
          end
          if (m_ptr[14]) m_ptr[10:0] = m_ptr[10:0] + 11'(n);
        end
      end
      default: word_v = 32'h0;
    endcase
    exp = 32'h0;
    for (int k = 0; k < 4; k++) if (be[k]) exp[8*k +: 8] = word_v[8*k +: 8];
  endtask

  task automatic bus(input logic we, input logic [1:0] w, input logic [3:0] be,
                     input logic [31:0] wd, input string tag, output logic [31:0] got);
    logic [31:0] exp;
    m_apply(we, w, be, wd, exp);
    host_req = 1'b1; host_we = we; host_word = w; host_be = be; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
    got = host_rdata;
    if (!we) begin
      chk({tag, " rvalid (R4)"}, {31'b0, host_rvalid}, 32'h1);
      chk(tag, host_rdata, exp);
    end
  endtask

  task automatic wr(input logic [1:0] w, input logic [3:0] be, input logic [31:0] wd);
    logic [31:0] dummy;
    bus(1'b1, w, be, wd, "wr", dummy);
  endtask

  task automatic set_ptr(input logic [15:0] p);
    wr(2'd1, 4'b1100, {p, 16'h0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R4 watchdog got hang exp completion");
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    be_set[0] = 4'b0001; be_set[1] = 4'b0010; be_set[2] = 4'b0100; be_set[3] = 4'b1000;
    be_set[4] = 4'b0011; be_set[5] = 4'b1100; be_set[6] = 4'b1111;
    m_bank = 3'd0; m_ptr = 16'h0;
    for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    void'($urandom(32'd4242));
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_word = 2'd0;
    host_be = 4'b0; host_wdata = 32'h0;
    repeat (3) @(negedge clk);
    chk("R1 rvalid in reset", {31'b0, host_rvalid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rvalid after reset", {31'b0, host_rvalid}, 32'h0);

    // R1/R3: reset bank and signature
    bus(1'b0, 2'd3, 4'b1111, 32'h0, "R1 R3 bank select after reset", rd);
    chk("R3 literal signature bank0", rd, 32'h3300_0000);

    // R9: pointer word in bank 0 is unimplemented
    wr(2'd1, 4'b1100, 32'hFFFF_0000);
    bus(1'b0, 2'd1, 4'b1111, 32'h0, "R9 bank0 word1 reads zero", rd);

    // R2: select bank 5, signature and bank readback
    wr(2'd3, 4'b0100, 32'h0005_0000);
    bus(1'b0, 2'd3, 4'b1100, 32'h0, "R2 R3 bank 5 readback", rd);
    chk("R3 literal bank5", rd, 32'h3305_0000);
    // R2: lane 3 alone does not change the bank
    wr(2'd3, 4'b1000, 32'h0700_0000);
    bus(1'b0, 2'd3, 4'b0100, 32'h0, "R2 lane3 write ignored", rd);

    // R1/R5: pointer reset value in bank 2
    wr(2'd3, 4'b0100, 32'h0002_0000);
    bus(1'b0, 2'd1, 4'b1100, 32'h0, "R1 R5 pointer after reset", rd);

    // fill both areas through the data port (R6, R7)
    set_ptr(16'h4000);
    for (int i = 0; i < 32; i++) wr(2'd2, 4'b1111, $urandom);
    set_ptr(16'hC000);
    for (int i = 0; i < 32; i++) wr(2'd2, 4'b1111, $urandom);
    bus(1'b0, 2'd1, 4'b1100, 32'h0, "R7 pointer after fill", rd);
    chk("R7 literal fill end", rd, 32'hC080_0000);

    // R5: byte-wise pointer write, reserved bits zero
    wr(2'd1, 4'b0100, 32'h00AB_0000);
    wr(2'd1, 4'b1000, 32'h1F00_0000);
    bus(1'b0, 2'd1, 4'b1111, 32'h0, "R5 bytewise pointer", rd);
    chk("R5 literal reserved zero", rd, 32'h07AB_0000);

    // R7: wrap at 2048 with a four-byte access
    set_ptr(16'h47FE);
    wr(2'd2, 4'b1111, 32'hDDCC_BBAA);
    bus(1'b0, 2'd1, 4'b1100, 32'h0, "R7 wrap", rd);
    chk("R7 literal wrap", rd, 32'h4002_0000);
    set_ptr(16'h67FE);
    bus(1'b0, 2'd2, 4'b1111, 32'h0, "R6 R7 read across wrap", rd);
    chk("R6 literal aliased bytes", rd, 32'hDDCC_BBAA);

    // R6: areas are independent, upper lanes map from pointer offset
    set_ptr(16'h4010);
    wr(2'd2, 4'b1100, 32'h2211_0000);
    set_ptr(16'hC010);
    wr(2'd2, 4'b0011, 32'h0000_4433);
    set_ptr(16'h6010);
    bus(1'b0, 2'd2, 4'b0011, 32'h0, "R6 tx area", rd);
    chk("R6 literal tx", rd, 32'h0000_2211);
    set_ptr(16'hE010);
    bus(1'b0, 2'd2, 4'b1100, 32'h0, "R6 rx area", rd);
    chk("R6 literal rx", rd, 32'h4433_0000);

    // R8: direction mismatches
    set_ptr(16'h6020);
    wr(2'd2, 4'b1111, 32'h5555_5555);
    bus(1'b0, 2'd1, 4'b1100, 32'h0, "R8 write in read mode no step", rd);
    chk("R8 literal ptr", rd, 32'h6020_0000);
    bus(1'b0, 2'd2, 4'b1111, 32'h0, "R8 data untouched", rd);
    set_ptr(16'h4030);
    bus(1'b0, 2'd2, 4'b1111, 32'h0, "R8 read in write mode zero", rd);
    chk("R8 literal zero", rd, 32'h0);
    bus(1'b0, 2'd1, 4'b1100, 32'h0, "R8 ptr unchanged", rd);

    // R7: no advance when bit 14 clear
    set_ptr(16'h0040);
    wr(2'd2, 4'b0001, 32'h0000_0077);
    bus(1'b0, 2'd1, 4'b1100, 32'h0, "R7 no autoinc", rd);
    chk("R7 literal hold", rd, 32'h0040_0000);

    // R9: data port outside bank 2 leaves buffer and pointer alone
    wr(2'd3, 4'b0100, 32'h0001_0000);
    wr(2'd2, 4'b1111, 32'h9999_9999);
    bus(1'b0, 2'd2, 4'b1111, 32'h0, "R9 bank1 data reads zero", rd);
    wr(2'd3, 4'b0100, 32'h0002_0000);
    set_ptr(16'h2040);
    bus(1'b0, 2'd2, 4'b0001, 32'h0, "R9 buffer unchanged", rd);
    bus(1'b0, 2'd0, 4'b1111, 32'h0, "R9 bank2 word0 zero", rd);

    // seeded random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [1:0] w;
      logic [3:0] be;
      string tag;
      op = int'($urandom % 10);
      be = be_set[$urandom % 7];
      if (op == 0) begin
        wr(2'd3, 4'b0100, {13'h0, (($urandom % 4) == 0) ? 3'($urandom) : 3'd2, 16'h0});
      end else if (op == 1) begin
        set_ptr(16'($urandom));
      end else if (op <= 4) begin
        wr(2'd2, be, $urandom);
      end else begin
        w = (op <= 7) ? 2'd2 : 2'($urandom);
        if (w == 2'd3) tag = "R3 random";
        else if (m_bank == 3'd2 && w == 2'd1) tag = "R5 random";
        else if (m_bank == 3'd2 && w == 2'd2) tag = "R6 random";
        else tag = "R9 random";
        bus(1'b0, w, be, 32'h0, tag, rd);
      end
    end
    bus(1'b0, 2'd1, 4'b1100, 32'h0, "R7 final pointer", rd);

    summary();
    $finish;
  end
endmodule